// File: doc/BRIEF.md
# Fault Event Ring Writer

This block turns fault reports into fixed-format 32-byte records and places them in a 16-slot circular ring that software drains. A fault arrives on a valid/ready port as one beat. The beat carries an 8-bit event code, a 20-bit substream ID, a stream ID, the faulting input address and the fetch address. The block packs these fields into eight 32-bit words. It presents the record on a one-cycle write port with the target slot number, then advances its producer pointer.

Software reads the producer pointer, takes records from the ring, and writes back its consumer pointer. Both pointers are five bits wide: a four-bit slot index and a wrap bit at bit 4. While the pointers differ and interrupts are enabled, a level interrupt stays high.

If a fault arrives while the ring is full, the fault is discarded. No record is overwritten. Instead, a one-cycle abort pulse goes to the global error logic. The block accepts events only while the queue-enable bit of the control word is set.

Top module: `evtq_writer`

## Requirements
- R1: After reset the producer and consumer pointers are 0, and `irq`, `rec_we` and `ovf_abort` are low.
- R2: An event accepted (`evt_valid` and `evt_ready` high at a clock edge) while the ring is not full gives `rec_we` high for exactly the following cycle. `rec_slot` equals the slot index of the producer before the edge, and the producer pointer has advanced by one, modulo 32.
- R3: The record holds eight words, with word k in `rec_data[32k+31:32k]`. Word 0 has the event code in bits 7:0, zero in bits 11:8 and the substream ID in bits 31:12. Word 1 is the stream ID. Words 2 and 3 are zero. Words 4 and 5 are the low and high halves of the input address. Words 6 and 7 are the low and high halves of the fetch address.
- R4: `evt_ready` follows bit 2 of `ctrl_word`. While that bit is clear, no record is written and the producer pointer does not change.
- R5: The ring is full when the slot indices of the two pointers are equal and their wrap bits differ. An event accepted while the ring is full is dropped: `rec_we` stays low, the producer is unchanged, and `ovf_abort` is high for exactly the next cycle.
- R6: `irq` is high exactly when bit 2 of `irq_ctrl` is set and the producer differs from the consumer, in all five bits.
- R7: A consumer write (`cons_wr_en`) loads `cons_wr_data` into the consumer pointer by the next cycle. Writing the producer's value clears `irq`.
- R8: With `evt_valid` held high, one record is written every cycle, and the fields are sampled each cycle.
- R9: The producer slot index wraps from 15 to 0 and the wrap bit toggles, so the 17th record lands in slot 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Control word; bit 2 enables the queue |
| irq_ctrl | input | 32 | Interrupt control; bit 2 enables the event interrupt |
| evt_valid | input | 1 | Fault event offered |
| evt_ready | output | 1 | Event accepted this cycle when valid |
| evt_code | input | 8 | Event code |
| evt_ssid | input | 20 | Substream ID |
| evt_sid | input | 32 | Stream ID |
| evt_in_addr | input | ADDR_W | Faulting input address |
| evt_fetch_addr | input | ADDR_W | Fetch address |
| cons_wr_en | input | 1 | Software consumer-pointer write strobe |
| cons_wr_data | input | 5 | New consumer pointer (wrap bit at bit 4) |
| prod_ptr | output | 5 | Producer pointer (wrap bit at bit 4) |
| cons_ptr | output | 5 | Consumer pointer (wrap bit at bit 4) |
| rec_we | output | 1 | Record write strobe |
| rec_slot | output | 4 | Ring slot of the record |
| rec_data | output | 256 | Eight-word record |
| irq | output | 1 | Event interrupt, level |
| ovf_abort | output | 1 | One-cycle abort pulse on a dropped event |

## Verification
A wrong pointer shows on `rec_slot` and `prod_ptr` in the cycle after the next accepted event. A broken full test shows either as a write while the ring is full or as a spurious `ovf_abort`, exposed on the first event after 16 unread records. A wrong wrap-bit handling shows only after the 16th record: the interrupt drops or the producer stalls. The fill-to-full sequence therefore crosses the wrap and then offers one more event. Field misplacement shows on `rec_data` in the same cycle as the write, so every vector checks all eight words.

// File: rtl/evtq_writer.sv
module evtq_writer #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 64,
  parameter int EN_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          ctrl_word,
  input  logic [31:0]          irq_ctrl,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [7:0]           evt_code,
  input  logic [19:0]          evt_ssid,
  input  logic [31:0]          evt_sid,
  input  logic [ADDR_W-1:0]    evt_in_addr,
  input  logic [ADDR_W-1:0]    evt_fetch_addr,
  input  logic                 cons_wr_en,
  input  logic [IDX_W:0]       cons_wr_data,
  output logic [IDX_W:0]       prod_ptr,
  output logic [IDX_W:0]       cons_ptr,
  output logic                 rec_we,
  output logic [IDX_W-1:0]     rec_slot,
  output logic [255:0]         rec_data,
  output logic                 irq,
  output logic                 ovf_abort
);
  localparam int PTR_W = IDX_W + 1;
  localparam int NWORD = 8;

  logic [PTR_W-1:0] prod_q, cons_q;
  logic [63:0]      in_ext, fetch_ext;
  logic [31:0]      word [NWORD];
  logic [255:0]     rec_next;
  logic             full, accept;

  assign in_ext    = 64'(evt_in_addr);
  assign fetch_ext = 64'(evt_fetch_addr);

  assign word[0] = {evt_ssid, 4'h0, evt_code};
  assign word[1] = evt_sid;
  assign word[2] = '0;
  assign word[3] = '0;
  assign word[4] = in_ext[31:0];
  assign word[5] = in_ext[63:32];
  assign word[6] = fetch_ext[31:0];
  assign word[7] = fetch_ext[63:32];

  for (genvar k = 0; k < NWORD; k++) begin : g_pack
    assign rec_next[32*k +: 32] = word[k];
  end

  assign full      = (prod_q[IDX_W-1:0] == cons_q[IDX_W-1:0]) && (prod_q[IDX_W] != cons_q[IDX_W]);
  assign evt_ready = ctrl_word[EN_BIT];
  assign accept    = evt_valid && evt_ready;
  assign irq       = irq_ctrl[EN_BIT] && (prod_q != cons_q);
  assign prod_ptr  = prod_q;
  assign cons_ptr  = cons_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q    <= '0;
      cons_q    <= '0;
      rec_we    <= 1'b0;
      rec_slot  <= '0;
      rec_data  <= '0;
      ovf_abort <= 1'b0;
    end else begin
      rec_we    <= 1'b0;
      ovf_abort <= 1'b0;
      if (accept) begin
        if (full) begin
          ovf_abort <= 1'b1;
        end else begin
          rec_we   <= 1'b1;
          rec_slot <= prod_q[IDX_W-1:0];
          rec_data <= rec_next;
          prod_q   <= prod_q + 1'b1;
        end
      end
      if (cons_wr_en) cons_q <= cons_wr_data;
    end
  end
endmodule

// File: rtl/evtq_writer_chk.sv
module evtq_writer_chk #(
  parameter int IDX_W  = 4,
  parameter int EN_BIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_word,
  input logic [31:0]      irq_ctrl,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic             cons_wr_en,
  input logic [IDX_W:0]   cons_wr_data,
  input logic [IDX_W:0]   prod_ptr,
  input logic [IDX_W:0]   cons_ptr,
  input logic             rec_we,
  input logic [IDX_W-1:0] rec_slot,
  input logic             irq,
  input logic             ovf_abort
);
  logic ring_full;
  assign ring_full = (prod_ptr[IDX_W-1:0] == cons_ptr[IDX_W-1:0]) && (prod_ptr[IDX_W] != cons_ptr[IDX_W]);

  assert_write_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !ring_full) |=> (rec_we && prod_ptr == $past(prod_ptr) + 1'b1
      && rec_slot == $past(prod_ptr[IDX_W-1:0])));

  assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && ring_full) |=> (!rec_we && ovf_abort && $stable(prod_ptr)));

  assert_ready_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[EN_BIT] |-> !evt_ready);

  assert_prod_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_ready) |=> ($stable(prod_ptr) && !rec_we));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ctrl[EN_BIT] |-> !irq);

  assert_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_ptr == cons_ptr) |-> !irq);

  assert_cons_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cons_wr_en |=> (cons_ptr == $past(cons_wr_data)));

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_we, ovf_abort}));
endmodule

bind evtq_writer evtq_writer_chk #(.IDX_W(IDX_W), .EN_BIT(EN_BIT)) chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .irq_ctrl(irq_ctrl),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .cons_wr_en(cons_wr_en),
  .cons_wr_data(cons_wr_data), .prod_ptr(prod_ptr), .cons_ptr(cons_ptr),
  .rec_we(rec_we), .rec_slot(rec_slot), .irq(irq), .ovf_abort(ovf_abort)
);

// File: tb/evtq_writer_test.sv
module evtq_writer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  ctrl_word = '0, irq_ctrl = '0;
  logic         evt_valid = 1'b0, evt_ready;
  logic [7:0]   evt_code = '0;
  logic [19:0]  evt_ssid = '0;
  logic [31:0]  evt_sid = '0;
  logic [63:0]  evt_in_addr = '0, evt_fetch_addr = '0;
  logic         cons_wr_en = 1'b0;
  logic [4:0]   cons_wr_data = '0;
  logic [4:0]   prod_ptr, cons_ptr;
  logic         rec_we, irq, ovf_abort;
  logic [3:0]   rec_slot;
  logic [255:0] rec_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evtq_writer uut (.*);

  localparam int NV = 6;
  localparam logic [7:0]  V_CODE [NV] = '{8'h10, 8'h13, 8'h02, 8'h25, 8'h0A, 8'hFF};
  localparam logic [19:0] V_SSID [NV] = '{20'h00000, 20'hFFFFF, 20'h12345, 20'hA5A5A, 20'h00001, 20'h80000};
  localparam logic [31:0] V_SID  [NV] = '{32'h0, 32'h3, 32'hFFFFFFFF, 32'h1234ABCD, 32'h80000000, 32'h7};
  localparam logic [63:0] V_IN   [NV] = '{64'h0000_0001_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                          64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEF};
  localparam logic [63:0] V_FET  [NV] = '{64'h0000_0000_0000_2000, 64'h0, 64'hFFFF_0000_FFFF_0000,
                                          64'h1111_2222_3333_4444, 64'h0000_0000_FFFF_FFFF, 64'hFEDC_BA98_7654_3210};

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mkrec(input logic [7:0] c, input logic [19:0] s, input logic [31:0] sid,
                                          input logic [63:0] ia, input logic [63:0] fa);
    return {fa[63:32], fa[31:0], ia[63:32], ia[31:0], 32'h0, 32'h0, sid, s, 4'h0, c};
  endfunction

  task automatic drive(input logic [7:0] c, input logic [19:0] s, input logic [31:0] sid,
                       input logic [63:0] ia, input logic [63:0] fa);
    evt_code = c; evt_ssid = s; evt_sid = sid; evt_in_addr = ia; evt_fetch_addr = fa;
  endtask

  task automatic send_one(input logic [7:0] c);
    @(negedge clk);
    drive(c, 20'h00ABC, 32'h55, 64'h10, 64'h20);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic write_cons(input logic [4:0] v);
    @(negedge clk);
    cons_wr_en = 1'b1; cons_wr_data = v;
    @(negedge clk);
    cons_wr_en = 1'b0;
  endtask

  initial begin
    logic [4:0] eprod;
    repeat (3) @(negedge clk);
    chk(prod_ptr == 0 && cons_ptr == 0, "R1 pointers", prod_ptr, 0);
    chk(!irq && !rec_we && !ovf_abort, "R1 outputs", {irq, rec_we, ovf_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ctrl_word = 32'h4; irq_ctrl = 32'h4;
    eprod = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(V_CODE[i], V_SSID[i], V_SID[i], V_IN[i], V_FET[i]);
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      chk(rec_we && rec_slot == eprod[3:0], "R2 write slot", {rec_we, rec_slot}, {1'b1, eprod[3:0]});
      eprod = eprod + 1;
      chk(prod_ptr == eprod, "R2 producer", prod_ptr, eprod);
      chk(rec_data == mkrec(V_CODE[i], V_SSID[i], V_SID[i], V_IN[i], V_FET[i]), "R3 record",
          rec_data, mkrec(V_CODE[i], V_SSID[i], V_SID[i], V_IN[i], V_FET[i]));
      chk(irq, "R6 irq pending", irq, 1);
      @(negedge clk);
      chk(!rec_we, "R2 single-cycle strobe", rec_we, 0);
    end

    write_cons(5'd6);
    chk(cons_ptr == 6, "R7 cons load", cons_ptr, 6);
    chk(!irq, "R7 irq clears", irq, 0);

    ctrl_word = 32'hFFFF_FFFB;
    @(negedge clk);
    chk(!evt_ready, "R4 ready low", evt_ready, 0);
    send_one(8'h01);
    chk(!rec_we && prod_ptr == 6, "R4 no write disabled", {rec_we, prod_ptr}, 6);
    ctrl_word = 32'h4;

    irq_ctrl = 32'hFFFF_FFFB;
    send_one(8'h03);
    chk(prod_ptr == 7, "R2 producer", prod_ptr, 7);
    chk(!irq, "R6 irq masked", irq, 0);
    irq_ctrl = 32'h4;
    @(negedge clk);
    chk(irq, "R6 irq unmasked", irq, 1);

    eprod = 7;
    @(negedge clk);
    evt_valid = 1'b1;
    drive(8'h20, 20'd0, 32'd0, 64'd0, 64'd0);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      chk(rec_we && rec_slot == eprod[3:0] && rec_data[31:0] == {20'd0, 4'h0, 8'h20 + 8'(k)},
          "R8 back-to-back", {rec_we, rec_slot, rec_data[31:0]}, {1'b1, eprod[3:0], 32'h20 + 32'(k)});
      eprod = eprod + 1;
      if (eprod == 5'h10) chk(prod_ptr == 5'h10, "R9 wrap bit", prod_ptr, 5'h10);
      if (k == 9) chk(rec_slot == 0, "R9 slot reuse", rec_slot, 0);
      if (k == 14) evt_valid = 1'b0;
      else drive(8'h21 + 8'(k), 20'd0, 32'd0, 64'd0, 64'd0);
    end
    chk(prod_ptr == 5'h16, "R9 producer after wrap", prod_ptr, 5'h16);
    chk(irq, "R6 irq full ring", irq, 1);

    send_one(8'h11);
    chk(!rec_we && ovf_abort && prod_ptr == 5'h16, "R5 drop on full",
        {rec_we, ovf_abort, prod_ptr}, {2'b01, 5'h16});
    @(negedge clk);
    chk(!ovf_abort, "R5 pulse one cycle", ovf_abort, 0);

    write_cons(5'h16);
    chk(!irq && cons_ptr == 5'h16, "R7 drain", {irq, cons_ptr}, 5'h16);
    send_one(8'h12);
    chk(rec_we && rec_slot == 6 && prod_ptr == 5'h17 && !ovf_abort, "R5 accepts after drain",
        {rec_we, rec_slot, prod_ptr}, {1'b1, 4'd6, 5'h17});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule